// File: doc/BRIEF.md
# Sector Write-Protection and Lockdown Controller

This block holds the write-protection state of a serial flash array split into 32 sectors of 64 KB. Each sector carries a volatile protect bit, which software can set and clear, and a lockdown bit that can only ever be set. Around these per-sector bits sit three global controls. The first is a lock bit that freezes the protect bits. A low level on the active-low write-protect pin stops that lock bit from being released. The second is a lockdown-enable bit, and a freeze command clears it for good. The third is the write-enable latch, which every state-changing command must find set.

A command front-end decodes the serial traffic. It hands this block one command pulse at the moment chip-select rises, together with the byte address, the status data byte and a flag that says whether the confirmation byte was correct. The block updates its state on that clock edge. One cycle later it reports a grant or a deny for each program or erase request, and it returns the protect and lockdown bits when asked. A two-bit summary field shows whether none, some or all sectors are protected.

Top module: `sect_guard`

## Requirements
- R1: After reset every protect bit is 1 and every lockdown bit is 0. The lock bit and the write-enable latch are 0, lockdown-enable is 1, and the summary field reads 11.
- R2: The enable command sets the write-enable latch and the disable command clears it. Each takes effect on the edge where the command is presented.
- R3: With the latch set and the lock bit at 0, a protect or unprotect command sets or clears only the sector chosen by address bits [20:16], and it clears the latch. With the latch clear, neither command changes anything.
- R4: While the lock bit is 1, protect and unprotect commands change no sector. They also leave the latch, the lock bit and lockdown-enable unchanged.
- R5: A status write needs the latch set and always clears it. When the lock bit is 0, the write protects every sector if data bit 2 is 1, unprotects every sector if it is 0, and loads data bit 7 into the lock bit.
- R6: When the lock bit is 1, a status write changes no sector. It clears the lock bit only if data bit 7 is 0 and the write-protect pin is high. While the pin is low the lock bit stays 1.
- R7: A status write issued while a program or erase is suspended changes no sector and leaves the lock bit unchanged, but it clears the latch.
- R8: A lockdown command with the latch set, lockdown-enable at 1 and a correct confirmation sets the addressed sector's lockdown bit, and no command clears that bit. In every case the command clears the latch.
- R9: A freeze command with the latch set and a correct confirmation clears lockdown-enable, and no command sets it again. Without the confirmation the freeze leaves lockdown-enable unchanged but still clears the latch.
- R10: The summary field reads 00 when no sector is protected, 01 when some are and 11 when all are. It never reads 10.
- R11: A program or erase request is granted exactly when the latch is set and the addressed sector is neither protected nor locked down. Otherwise it is denied. Either way the latch is cleared, and the grant or deny pulse appears one cycle after the request.
- R12: A protection read returns the addressed sector's protect and lockdown bits, with a valid pulse, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command commits |
| cmd_op | input | 4 | Command code (package enumeration) |
| cmd_addr | input | 21 | Byte address; bits [20:16] choose the sector |
| cmd_wdata | input | 8 | Status data byte (bit 7 lock bit, bit 2 global protect) |
| cmd_confirm | input | 1 | Confirmation byte was correct |
| wp_n | input | 1 | Write-protect pin, active low |
| suspended | input | 1 | A program or erase is currently suspended |
| wel | output | 1 | Write-enable latch |
| sprl | output | 1 | Protection lock bit |
| lock_en | output | 1 | Lockdown-enable bit |
| swp | output | 2 | Protection summary field |
| pe_grant | output | 1 | Program/erase request granted (pulse) |
| pe_deny | output | 1 | Program/erase request denied (pulse) |
| rd_valid | output | 1 | Protection read result valid (pulse) |
| rd_prot | output | 1 | Protect bit of the sector that was read |
| rd_lock | output | 1 | Lockdown bit of the sector that was read |

## Verification
The assertions check on every cycle the one-way properties. A lockdown bit never falls, lockdown-enable never rises, and the lock bit survives while the pin is low. They also check that the summary never shows 10, that grant and deny never coincide, that a request always clears the latch, and that the protect bits stay fixed under a locked or suspended write. Only the bench scenarios can show which sector a command hits, what a global write leaves behind, how sector state interacts with grant decisions across the whole array, and the abort paths of lockdown and freeze.

// File: rtl/sg_pkg.sv
// Shared types for the sector write-protection controller.
// Assumes the command front-end produces one sg_op_e pulse per chip-select rise.
package sg_pkg;

    typedef enum logic [3:0] {
        OP_NONE      = 4'd0,
        OP_WREN      = 4'd1,
        OP_WRDI      = 4'd2,
        OP_PROTECT   = 4'd3,
        OP_UNPROTECT = 4'd4,
        OP_STATUS_WR = 4'd5,
        OP_LOCKDOWN  = 4'd6,
        OP_FREEZE    = 4'd7,
        OP_PE_REQ    = 4'd8,
        OP_RD_PROT   = 4'd9
    } sg_op_e;

    // Bit positions inside the status data byte.
    localparam int STAT_LOCK_BIT = 7;
    localparam int STAT_GLOB_BIT = 2;

    // Update strobes from the controller to the sector bank.
    typedef struct packed {
        logic set_one;
        logic clr_one;
        logic set_all;
        logic clr_all;
        logic lock_one;
    } sg_upd_t;

endpackage

// File: rtl/sg_sector_bank.sv
// Per-sector protect and lockdown storage.
// Assumes NUM_SECT == 2**IDX_W; set_all/clr_all have priority over single-sector strobes.
// Lockdown bits are modelled as sticky flops loaded clear at reset.
module sg_sector_bank #(
    parameter int NUM_SECT = 32,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sg_pkg::sg_upd_t     upd,
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_SECT-1:0] prot_q,
    output logic [NUM_SECT-1:0] lock_q,
    output logic                sel_prot,
    output logic                sel_lock
);

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        logic hit;
        assign hit = (idx == IDX_W'(g));

        // Protect bit: global strobes first, then the addressed-sector strobes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prot_q[g] <= 1'b1;
            end else if (upd.set_all) begin
                prot_q[g] <= 1'b1;
            end else if (upd.clr_all) begin
                prot_q[g] <= 1'b0;
            end else if (hit && upd.set_one) begin
                prot_q[g] <= 1'b1;
            end else if (hit && upd.clr_one) begin
                prot_q[g] <= 1'b0;
            end
        end

        // Lockdown bit: may only move from 0 to 1.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[g] <= 1'b0;
            end else if (hit && upd.lock_one) begin
                lock_q[g] <= 1'b1;
            end
        end
    end

    // Select the addressed sector's bits for decisions and reads.
    always_comb begin
        sel_prot = prot_q[idx];
        sel_lock = lock_q[idx];
    end

endmodule

// File: rtl/sg_swp_enc.sv
// Summary encoder: 00 none protected, 01 some protected, 11 all protected.
// Purely combinational over the protect vector.
module sg_swp_enc #(
    parameter int NUM_SECT = 32
) (
    input  logic [NUM_SECT-1:0] prot_q,
    output logic [1:0]          swp
);

    // Reduce the vector into the two-bit summary.
    always_comb begin
        if (&prot_q) begin
            swp = 2'b11;
        end else if (|prot_q) begin
            swp = 2'b01;
        end else begin
            swp = 2'b00;
        end
    end

endmodule

// File: rtl/sg_ctrl.sv
// Command decision logic: write-enable latch, lock bit, lockdown-enable,
// bank update strobes and the registered grant/deny and read results.
// Assumes one command per cmd_valid pulse, already validated for byte framing.
module sg_ctrl (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  sg_pkg::sg_op_e  op,
    input  logic            dat_lock,
    input  logic            dat_glob,
    input  logic            confirm,
    input  logic            wp_n,
    input  logic            suspended,
    input  logic            sel_prot,
    input  logic            sel_lock,
    output sg_pkg::sg_upd_t upd,
    output logic            wel,
    output logic            sprl,
    output logic            lock_en,
    output logic            pe_grant,
    output logic            pe_deny,
    output logic            rd_valid,
    output logic            rd_prot,
    output logic            rd_lock
);
    import sg_pkg::*;

    logic wel_nxt, sprl_nxt, lde_nxt;
    logic grant_nxt, deny_nxt, rdv_nxt;

    // Decide next state and bank strobes for the committing command.
    always_comb begin
        upd       = '0;
        wel_nxt   = wel;
        sprl_nxt  = sprl;
        lde_nxt   = lock_en;
        grant_nxt = 1'b0;
        deny_nxt  = 1'b0;
        rdv_nxt   = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_WREN: wel_nxt = 1'b1;
                OP_WRDI: wel_nxt = 1'b0;
                OP_PROTECT, OP_UNPROTECT: begin
                    if (!sprl && wel) begin
                        upd.set_one = (op == OP_PROTECT);
                        upd.clr_one = (op == OP_UNPROTECT);
                        wel_nxt     = 1'b0;
                    end
                end
                OP_STATUS_WR: begin
                    if (wel) begin
                        wel_nxt = 1'b0;
                        if (!suspended) begin
                            if (!sprl) begin
                                upd.set_all = dat_glob;
                                upd.clr_all = !dat_glob;
                                sprl_nxt    = dat_lock;
                            end else if (wp_n && !dat_lock) begin
                                sprl_nxt = 1'b0;
                            end
                        end
                    end
                end
                OP_LOCKDOWN: begin
                    if (wel) begin
                        wel_nxt      = 1'b0;
                        upd.lock_one = lock_en && confirm;
                    end
                end
                OP_FREEZE: begin
                    if (wel) begin
                        wel_nxt = 1'b0;
                        if (confirm) begin
                            lde_nxt = 1'b0;
                        end
                    end
                end
                OP_PE_REQ: begin
                    wel_nxt   = 1'b0;
                    grant_nxt = wel && !sel_prot && !sel_lock;
                    deny_nxt  = !(wel && !sel_prot && !sel_lock);
                end
                OP_RD_PROT: rdv_nxt = 1'b1;
                default: ;
            endcase
        end
    end

    // Register global control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel     <= 1'b0;
            sprl    <= 1'b0;
            lock_en <= 1'b1;
        end else begin
            wel     <= wel_nxt;
            sprl    <= sprl_nxt;
            lock_en <= lde_nxt;
        end
    end

    // Register the one-cycle result pulses and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_grant <= 1'b0;
            pe_deny  <= 1'b0;
            rd_valid <= 1'b0;
            rd_prot  <= 1'b0;
            rd_lock  <= 1'b0;
        end else begin
            pe_grant <= grant_nxt;
            pe_deny  <= deny_nxt;
            rd_valid <= rdv_nxt;
            if (rdv_nxt) begin
                rd_prot <= sel_prot;
                rd_lock <= sel_lock;
            end
        end
    end

endmodule

// File: rtl/sect_guard.sv
// Top of the sector write-protection and lockdown controller.
// Assumes the front-end commits each command with a single cmd_valid pulse at chip-select rise.
module sect_guard #(
    parameter int NUM_SECT   = 32,
    parameter int SECT_SHIFT = 16,
    parameter int ADDR_W     = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              cmd_confirm,
    input  logic              wp_n,
    input  logic              suspended,
    output logic              wel,
    output logic              sprl,
    output logic              lock_en,
    output logic [1:0]        swp,
    output logic              pe_grant,
    output logic              pe_deny,
    output logic              rd_valid,
    output logic              rd_prot,
    output logic              rd_lock
);
    import sg_pkg::*;

    localparam int IDX_W = $clog2(NUM_SECT);

    sg_op_e              op_e;
    sg_upd_t             upd;
    logic [IDX_W-1:0]    idx;
    logic [NUM_SECT-1:0] prot_q;
    logic [NUM_SECT-1:0] lock_q;
    logic                sel_prot, sel_lock;
    logic                unused_bits;

    assign op_e = sg_op_e'(cmd_op);
    assign idx  = cmd_addr[SECT_SHIFT +: IDX_W];
    assign unused_bits = ^{cmd_addr[SECT_SHIFT-1:0], cmd_wdata[6:3], cmd_wdata[1:0]};

    sg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op_e),
        .dat_lock  (cmd_wdata[STAT_LOCK_BIT]),
        .dat_glob  (cmd_wdata[STAT_GLOB_BIT]),
        .confirm   (cmd_confirm),
        .wp_n      (wp_n),
        .suspended (suspended),
        .sel_prot  (sel_prot),
        .sel_lock  (sel_lock),
        .upd       (upd),
        .wel       (wel),
        .sprl      (sprl),
        .lock_en   (lock_en),
        .pe_grant  (pe_grant),
        .pe_deny   (pe_deny),
        .rd_valid  (rd_valid),
        .rd_prot   (rd_prot),
        .rd_lock   (rd_lock)
    );

    sg_sector_bank #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .idx      (idx),
        .prot_q   (prot_q),
        .lock_q   (lock_q),
        .sel_prot (sel_prot),
        .sel_lock (sel_lock)
    );

    sg_swp_enc #(.NUM_SECT(NUM_SECT)) u_enc (
        .prot_q (prot_q),
        .swp    (swp)
    );

endmodule

// File: rtl/sect_guard_chk.sv
// Property checker bound into sect_guard; observes ports and bank state only.
module sect_guard_chk #(
    parameter int NUM_SECT = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [3:0]          cmd_op,
    input logic                wp_n,
    input logic                suspended,
    input logic                wel,
    input logic                sprl,
    input logic                lock_en,
    input logic [1:0]          swp,
    input logic                pe_grant,
    input logic                pe_deny,
    input logic [NUM_SECT-1:0] prot_q,
    input logic [NUM_SECT-1:0] lock_q
);
    import sg_pkg::*;

    AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R8
    AST_LDE_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(lock_en)); // R9
    AST_LOCK_HELD_BY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (sprl && !wp_n) |=> sprl); // R6
    AST_SUSPEND_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STATUS_WR && suspended) |=> $stable(prot_q) && $stable(sprl)); // R7
    AST_LOCKED_IGNORES_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_PROTECT || cmd_op == OP_UNPROTECT) && sprl)
        |=> $stable(prot_q) && $stable(wel)); // R4
    AST_SWP_NO_TEN: assert property (@(posedge clk) disable iff (!rst_n)
        swp != 2'b10); // R10
    AST_SWP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&prot_q) |-> swp == 2'b11); // R10
    AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pe_grant && pe_deny)); // R11
    AST_PE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PE_REQ) |=> !wel); // R11
    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        pe_grant |-> $past(wel)); // R11

endmodule

bind sect_guard sect_guard_chk #(.NUM_SECT(NUM_SECT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wp_n      (wp_n),
    .suspended (suspended),
    .wel       (wel),
    .sprl      (sprl),
    .lock_en   (lock_en),
    .swp       (swp),
    .pe_grant  (pe_grant),
    .pe_deny   (pe_deny),
    .prot_q    (prot_q),
    .lock_q    (lock_q)
);

// File: tb/sim_sect_guard.sv
module sim_sect_guard;
    import sg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [20:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        cmd_confirm = 1'b0;
    logic        wp_n = 1'b1;
    logic        suspended = 1'b0;
    logic        wel, sprl, lock_en, pe_grant, pe_deny, rd_valid, rd_prot, rd_lock;
    logic [1:0]  swp;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] exp_prot;
    logic [31:0] exp_lock;

    always #2 clk = ~clk;

    sect_guard u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_confirm(cmd_confirm),
        .wp_n(wp_n), .suspended(suspended), .wel(wel), .sprl(sprl),
        .lock_en(lock_en), .swp(swp), .pe_grant(pe_grant), .pe_deny(pe_deny),
        .rd_valid(rd_valid), .rd_prot(rd_prot), .rd_lock(rd_lock)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] swp_of(logic [31:0] p);
        return (p == 32'hFFFF_FFFF) ? 2'b11 : (p != 0) ? 2'b01 : 2'b00;
    endfunction

    // Present one command for one cycle; returns on the negedge after the commit edge.
    task automatic cmd(sg_op_e op, int sect, logic [7:0] d, logic conf);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_addr    = {sect[4:0], 16'h0A5C};
        cmd_wdata   = d;
        cmd_confirm = conf;
        @(negedge clk);
        cmd_valid   = 1'b0;
        cmd_op      = OP_NONE;
    endtask

    task automatic read_sect(int s, string tag);
        cmd(OP_RD_PROT, s, 8'h00, 1'b0);
        check({tag, " rd_valid"}, rd_valid, 1);
        check({tag, " rd_prot"}, rd_prot, exp_prot[s]);
        check({tag, " rd_lock"}, rd_lock, exp_lock[s]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_prot = 32'hFFFF_FFFF;
        exp_lock = 32'h0;
        // R1 reset state
        check("R1 wel", wel, 0);
        check("R1 sprl", sprl, 0);
        check("R1 lock_en", lock_en, 1);
        check("R1 swp", swp, 2'b11);
        read_sect(17, "R1");

        // R2 latch set / clear
        cmd(OP_WREN, 0, 0, 0);  check("R2 set", wel, 1);
        cmd(OP_WRDI, 0, 0, 0);  check("R2 clr", wel, 0);

        // R3 unprotect without latch does nothing
        cmd(OP_UNPROTECT, 3, 0, 0);
        read_sect(3, "R3 nowel");

        // R3/R10 sweep: unprotect every sector in turn
        for (int s = 0; s < 32; s++) begin
            cmd(OP_WREN, 0, 0, 0);
            cmd(OP_UNPROTECT, s, 0, 0);
            exp_prot[s] = 1'b0;
            check("R3 wel cleared", wel, 0);
            check("R10 swp", swp, swp_of(exp_prot));
        end
        // R3/R12 reprotect even sectors, read all back
        for (int s = 0; s < 32; s += 2) begin
            cmd(OP_WREN, 0, 0, 0);
            cmd(OP_PROTECT, s, 0, 0);
            exp_prot[s] = 1'b1;
        end
        check("R10 swp some", swp, 2'b01);
        for (int s = 0; s < 32; s++) read_sect(s, "R12");

        // R11 program/erase sweep
        for (int s = 0; s < 32; s++) begin
            cmd(OP_WREN, 0, 0, 0);
            cmd(OP_PE_REQ, s, 0, 0);
            check("R11 grant", pe_grant, (s % 2));
            check("R11 deny", pe_deny, 1 - (s % 2));
            check("R11 wel", wel, 0);
        end
        cmd(OP_PE_REQ, 1, 0, 0);
        check("R11 nowel deny", pe_deny, 1);

        // R5 global protect, and status write without latch is ignored
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_STATUS_WR, 0, 8'h04, 0);
        exp_prot = 32'hFFFF_FFFF;
        check("R5 swp all", swp, 2'b11);
        check("R5 wel", wel, 0);
        cmd(OP_STATUS_WR, 0, 8'h00, 0);
        check("R5 nowel ignored", swp, 2'b11);
        // R5 global unprotect with lock bit set
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_STATUS_WR, 0, 8'h80, 0);
        exp_prot = 32'h0;
        check("R5 swp none", swp, 2'b00);
        check("R5 sprl", sprl, 1);

        // R4 protect ignored while locked, latch kept
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_PROTECT, 5, 0, 0);
        check("R4 wel kept", wel, 1);
        check("R4 swp", swp, 2'b00);
        read_sect(5, "R4");

        // R6 pin low keeps the lock bit
        wp_n = 1'b0;
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_STATUS_WR, 0, 8'h04, 0);
        check("R6 sprl held", sprl, 1);
        check("R6 wel", wel, 0);
        check("R6 swp", swp, 2'b00);
        wp_n = 1'b1;
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_STATUS_WR, 0, 8'h04, 0);
        check("R6 sprl released", sprl, 0);
        check("R6 swp unchanged", swp, 2'b00);

        // R7 suspended status write aborts
        suspended = 1'b1;
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_STATUS_WR, 0, 8'h84, 0);
        check("R7 swp", swp, 2'b00);
        check("R7 sprl", sprl, 0);
        check("R7 wel", wel, 0);
        suspended = 1'b0;

        // R8 lockdown
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_LOCKDOWN, 7, 0, 1);
        exp_lock[7] = 1'b1;
        check("R8 wel", wel, 0);
        read_sect(7, "R8");
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_PE_REQ, 7, 0, 0);
        check("R8 locked deny", pe_deny, 1);
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_LOCKDOWN, 8, 0, 0);
        check("R8 noconf wel", wel, 0);
        read_sect(8, "R8 noconf");
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_STATUS_WR, 0, 8'h00, 0);
        read_sect(7, "R8 survives global");

        // R9 freeze
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_FREEZE, 0, 0, 0);
        check("R9 abort lde", lock_en, 1);
        check("R9 abort wel", wel, 0);
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_FREEZE, 0, 0, 1);
        check("R9 lde cleared", lock_en, 0);
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_LOCKDOWN, 9, 0, 1);
        check("R9 wel", wel, 0);
        read_sect(9, "R9 no lockdown");
        cmd(OP_WREN, 0, 0, 0);
        cmd(OP_PE_REQ, 9, 0, 0);
        check("R11 free sector grant", pe_grant, 1);

        finish_run();
    end
endmodule